// File: doc/BRIEF.md
# Two-Channel Indirect Coefficient RAM Bridge

This block sits between a serial host port and a coefficient RAM that belongs to a signal-processing engine. The host never reaches the RAM directly. It sends short frames over an already deserialized byte stream. Each frame carries a control byte, an address byte and a data word. The block keeps an address buffer, a data buffer, a request kind, a pending flag and an interrupt flag for each of two channels. Frames therefore leave requests queued per channel, and the block carries them out later on a plain synchronous RAM port.

The RAM may only be touched inside service windows, which a pulse on `svc_win` opens. In each window the block visits channel 0 and then channel 1. It performs at most one access per channel, and only for a channel that has a request pending. Reads are pipelined one deep. When the address byte of a read frame arrives, the block places that channel's current data buffer on the outgoing word stream. That value is the result of the previous read on that channel. The new address is only queued for the next window.

The outgoing word stream follows valid/ready rules. `tx_data` is held stable while `tx_valid` is high and `tx_ready` is low. While a word waits, `in_ready` is low, so the host byte stream is stalled rather than dropped. The inbound stream has no other source of back-pressure.

Top module: `ibr_top`

## Requirements
- R1: A byte with `in_first` high is a control byte. Bit 7 = 1 means read and bit 7 = 0 means write; bit 0 selects the channel. If any of bits 6..1 is set, no frame starts. The next accepted byte is the address, and the two bytes after that are the data word, high byte first. A byte without `in_first` that arrives outside a frame is ignored.
- R2: The cycle after a read's address byte is accepted, `tx_valid` rises. `tx_data` then carries that channel's data buffer, which holds the result of the previous serviced read on the channel, or the last written data, or 0 after reset.
- R3: While `tx_valid` is high and `tx_ready` is low, `tx_data` stays stable and `in_ready` is low. A word leaves on the cycle where `tx_valid` and `tx_ready` are both high.
- R4: When the last data byte of a frame is accepted, a request is logged: `busy[ch]` is high from the next cycle. A write also loads its address and data into the channel's buffers.
- R5: The RAM is accessed only after a `svc_win` pulse. Within a window, channel 0 is served before channel 1, and each channel is accessed at most once. An access uses the channel's buffered address, with `ram_we` = 1 and the buffered data for a write, or `ram_we` = 0 for a read.
- R6: Servicing a request clears `busy[ch]` and sets that channel's interrupt flag. `irq[ch]` is the flag gated by `irq_en[ch]`. `irq_clr[ch]` clears the flag unless a service sets it in the same cycle.
- R7: A serviced read loads `ram_rdata`, which arrives one cycle after the access, into the channel's data buffer.
- R8: A new request on a channel that is still pending replaces the buffered request, `busy` stays high, and only the newest request reaches the RAM.
- R9: The two channels keep separate buffers and flags. Requests may be pending on both at once, and one window serves both.
- R10: After reset, `busy`, `irq` and `tx_valid` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound byte valid |
| in_ready | output | 1 | Inbound byte accepted when high |
| in_first | input | 1 | Marks a control byte |
| in_data | input | 8 | Inbound byte |
| tx_valid | output | 1 | Outgoing read word valid |
| tx_ready | input | 1 | Outgoing word taken |
| tx_data | output | 16 | Outgoing read word |
| svc_win | input | 1 | Service window pulse |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after access |
| busy | output | 2 | Per-channel request pending |
| irq_en | input | 2 | Per-channel interrupt enable |
| irq_clr | input | 2 | Per-channel interrupt flag clear |
| irq | output | 2 | Per-channel interrupt |

## Verification
The assertions check several properties on every cycle. A held outgoing word must stay stable. A logged request must raise `busy`. Every RAM access must find a channel pending. Two accesses may never fall in back-to-back cycles, and a window may not carry more accesses than there are channels. A completion must hit a pending channel and leave its interrupt flag set. Other behaviour can only be shown through the bench's scenarios: the one-deep read pipeline, the replacement of a queued request on a busy channel, the order of channels within a window, and the absence of RAM traffic when no window is given. The bench's reference model tracks these frame by frame.

// File: rtl/ibr_pkg.sv
package ibr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_e;
  typedef enum logic [1:0] {SV_IDLE, SV_SCAN, SV_WAIT} svc_e;
  localparam int RD_BIT = 7;
endpackage

// File: rtl/ibr_frame_rx.sv
module ibr_frame_rx
  import ibr_pkg::*;
#(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NCH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         byte_valid,
  input  logic                         byte_take,
  input  logic                         byte_first,
  input  logic [7:0]                   byte_data,
  output logic                         tx_load,
  output logic                         req_log,
  output logic                         req_rd,
  output logic [$clog2(NCH)-1:0]       req_ch,
  output logic [AW-1:0]                req_addr,
  output logic [DW-1:0]                req_data
);
  localparam int NB   = DW / 8;
  localparam int CHW  = $clog2(NCH);
  localparam int NBW  = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [7:0] KEEP = 8'h80 | 8'((1 << CHW) - 1);

  phase_e          ph_q;
  logic            rd_q;
  logic [CHW-1:0]  ch_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic [NBW-1:0]  cnt_q;
  logic            acc, mid, ctl_ok;

  assign acc    = byte_valid & byte_take;
  assign mid    = acc & ~byte_first;
  assign ctl_ok = (byte_data & ~KEEP) == 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      rd_q   <= 1'b0;
      ch_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
      cnt_q  <= '0;
    end else if (acc && byte_first) begin
      ph_q <= ctl_ok ? PH_ADDR : PH_IDLE;
      rd_q <= byte_data[RD_BIT];
      ch_q <= byte_data[CHW-1:0];
    end else if (mid) begin
      case (ph_q)
        PH_ADDR: begin
          addr_q <= byte_data[AW-1:0];
          cnt_q  <= '0;
          ph_q   <= PH_DATA;
        end
        PH_DATA: begin
          data_q <= req_data;
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == NBW'(NB - 1)) ph_q <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign tx_load  = mid && (ph_q == PH_ADDR) && rd_q;
  assign req_log  = mid && (ph_q == PH_DATA) && (cnt_q == NBW'(NB - 1));
  assign req_rd   = rd_q;
  assign req_ch   = ch_q;
  assign req_addr = addr_q;
  assign req_data = (data_q << 8) | DW'(byte_data);

  // R1
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && byte_first && !ctl_ok) |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/ibr_chan.sv
module ibr_chan #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          log_req,
  input  logic          log_rd,
  input  logic [AW-1:0] log_addr,
  input  logic [DW-1:0] log_data,
  input  logic          issue,
  input  logic          done,
  input  logic          cap_rd,
  input  logic [DW-1:0] rdata,
  input  logic          flag_clr,
  output logic          busy,
  output logic          kind_rd,
  output logic [AW-1:0] abuf,
  output logic [DW-1:0] dbuf,
  output logic          flag
);
  logic relog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      kind_rd <= 1'b0;
      abuf    <= '0;
      dbuf    <= '0;
      flag    <= 1'b0;
      relog_q <= 1'b0;
    end else begin
      if (issue && log_req) relog_q <= 1'b1;
      else if (done)        relog_q <= 1'b0;

      if (log_req)                busy <= 1'b1;
      else if (done && !relog_q)  busy <= 1'b0;

      if (log_req) begin
        kind_rd <= log_rd;
        abuf    <= log_addr;
      end

      if (log_req && !log_rd) dbuf <= log_data;
      else if (cap_rd)        dbuf <= rdata;

      if (done)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  // R4
  log_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |=> busy);
  // R6
  done_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R6
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag);
endmodule

// File: rtl/ibr_svc.sv
module ibr_svc
  import ibr_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   svc_win,
  input  logic [NCH-1:0]         busy,
  input  logic [NCH-1:0]         kind_rd,
  output logic [NCH-1:0]         issue,
  output logic [NCH-1:0]         done,
  output logic                   cap_rd,
  output logic [$clog2(NCH)-1:0] sel
);
  localparam int CHW = $clog2(NCH);

  svc_e           st_q;
  logic [CHW-1:0] idx_q;
  logic           was_rd_q;
  logic [CHW:0]   acc_n_q;
  logic           last;

  assign last = (idx_q == CHW'(NCH - 1));
  assign sel  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SV_IDLE;
      idx_q    <= '0;
      was_rd_q <= 1'b0;
    end else begin
      case (st_q)
        SV_IDLE: if (svc_win) begin
          st_q  <= SV_SCAN;
          idx_q <= '0;
        end
        SV_SCAN: begin
          if (busy[idx_q]) begin
            st_q     <= SV_WAIT;
            was_rd_q <= kind_rd[idx_q];
          end else if (last) st_q <= SV_IDLE;
          else idx_q <= idx_q + 1'b1;
        end
        SV_WAIT: begin
          if (last) st_q <= SV_IDLE;
          else begin
            st_q  <= SV_SCAN;
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= SV_IDLE;
      endcase
    end
  end

  always_comb begin
    issue = '0;
    done  = '0;
    for (int i = 0; i < NCH; i++) begin
      issue[i] = (st_q == SV_SCAN) && (idx_q == CHW'(i)) && busy[i];
      done[i]  = (st_q == SV_WAIT) && (idx_q == CHW'(i));
    end
  end
  assign cap_rd = (st_q == SV_WAIT) && was_rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n || st_q == SV_IDLE) acc_n_q <= '0;
    else if (|issue)               acc_n_q <= acc_n_q + 1'b1;
  end

  // R5
  per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_n_q <= (CHW+1)'(NCH));
  // R5
  issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue) |=> !(|issue));
endmodule

// File: rtl/ibr_top.sv
module ibr_top #(
  parameter int AW  = 8,
  parameter int DW  = 16,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic           in_first,
  input  logic [7:0]     in_data,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [DW-1:0]  tx_data,
  input  logic           svc_win,
  output logic           ram_en,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata,
  output logic [NCH-1:0] busy,
  input  logic [NCH-1:0] irq_en,
  input  logic [NCH-1:0] irq_clr,
  output logic [NCH-1:0] irq
);
  localparam int CHW = $clog2(NCH);

  logic           tx_load, req_log, req_rd;
  logic [CHW-1:0] req_ch, sel;
  logic [AW-1:0]  req_addr;
  logic [DW-1:0]  req_data;
  logic [NCH-1:0] issue, done, kind_rd, flag;
  logic           cap_rd;
  logic [AW-1:0]  c_abuf [NCH];
  logic [DW-1:0]  c_dbuf [NCH];

  assign in_ready = ~tx_valid;

  ibr_frame_rx #(.AW(AW), .DW(DW), .NCH(NCH)) u_rx (
    .clk(clk), .rst_n(rst_n), .byte_valid(in_valid), .byte_take(in_ready),
    .byte_first(in_first), .byte_data(in_data), .tx_load(tx_load),
    .req_log(req_log), .req_rd(req_rd), .req_ch(req_ch),
    .req_addr(req_addr), .req_data(req_data));

  ibr_svc #(.NCH(NCH)) u_svc (
    .clk(clk), .rst_n(rst_n), .svc_win(svc_win), .busy(busy),
    .kind_rd(kind_rd), .issue(issue), .done(done), .cap_rd(cap_rd), .sel(sel));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ibr_chan #(.AW(AW), .DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .log_req(req_log && req_ch == CHW'(g)), .log_rd(req_rd),
      .log_addr(req_addr), .log_data(req_data),
      .issue(issue[g]), .done(done[g]), .cap_rd(cap_rd && done[g]),
      .rdata(ram_rdata), .flag_clr(irq_clr[g]),
      .busy(busy[g]), .kind_rd(kind_rd[g]), .abuf(c_abuf[g]),
      .dbuf(c_dbuf[g]), .flag(flag[g]));
  end

  assign ram_en    = |issue;
  assign ram_we    = ~kind_rd[sel];
  assign ram_addr  = c_abuf[sel];
  assign ram_wdata = c_dbuf[sel];
  assign irq       = flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (tx_load) begin
      tx_valid <= 1'b1;
      tx_data  <= c_dbuf[req_ch];
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R5
  ram_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |-> (|busy));
endmodule

// File: tb/ibr_top_test.sv
module ibr_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_first = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        tx_ready = 1'b1, svc_win = 1'b0;
  logic [1:0]  irq_en = 2'b00, irq_clr = 2'b00;
  logic [15:0] ram_rdata = 16'h0000;
  logic        in_ready, tx_valid, ram_en, ram_we;
  logic [15:0] tx_data, ram_wdata;
  logic [7:0]  ram_addr;
  logic [1:0]  busy, irq;

  always #4 clk = ~clk;

  ibr_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .svc_win(svc_win),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .busy(busy),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq));

  int checks = 0, fails = 0, cycles = 0, ram_cnt = 0, tx_cnt = 0;
  logic [15:0] last_tx;
  logic [15:0] mem [256];

  function automatic logic [15:0] memval(input int a);
    return 16'((a * 257) ^ 16'h5a5a);
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // RAM behaviour
  always @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    ram_rdata <= mem[ram_addr];
  end

  // Reference model
  int ph = 0, cnt = 0;
  bit f_rd; int f_ch; logic [7:0] f_addr; logic [15:0] f_data;
  bit pend[2], relog[2], irqf[2], kind[2], served[2];
  logic [7:0] abuf[2]; logic [15:0] dbuf[2];
  bit txv; logic [15:0] txd;
  bit dn; int dn_ch; bit dn_rd; logic [15:0] dn_val;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; txv = 0; txd = 0; dn = 0;
      for (int i = 0; i < 2; i++) begin
        pend[i] = 0; relog[i] = 0; irqf[i] = 0; kind[i] = 0;
        abuf[i] = 0; dbuf[i] = 0; served[i] = 0;
      end
    end else begin
      bit lg; bit ld; int lch;
      lg = 0; ld = 0; lch = 0;
      if (in_valid && !txv) begin
        if (in_first) begin
          ph = ((in_data & 8'h7e) == 0) ? 1 : 0;
          f_rd = in_data[7]; f_ch = int'(in_data[0]);
        end else if (ph == 1) begin
          f_addr = in_data; ph = 2; cnt = 0; ld = f_rd;
        end else if (ph == 2) begin
          f_data = {f_data[7:0], in_data}; cnt++;
          if (cnt == 2) begin lg = 1; lch = f_ch; ph = 0; end
        end
      end
      // tx handshake and load use buffer contents from before this edge
      if (txv && tx_ready) txv = 0;
      if (ld) begin txv = 1; txd = dbuf[f_ch]; end
      for (int i = 0; i < 2; i++) if (irq_clr[i]) irqf[i] = 0;
      if (dn) begin
        if (dn_rd) dbuf[dn_ch] = dn_val;
        if (!relog[dn_ch]) pend[dn_ch] = 0;
        relog[dn_ch] = 0; irqf[dn_ch] = 1; dn = 0;
      end
      if (ram_en) begin
        int c;
        c = (pend[0] && !served[0]) ? 0 : 1;
        ram_cnt++;
        chk(pend[c] && !served[c], "R5 access without pending request", 32'(ram_en), 32'(pend[c]));
        chk(ram_addr == abuf[c], "R5 ram_addr", 32'(ram_addr), 32'(abuf[c]));
        chk(ram_we == !kind[c], "R5 ram_we", 32'(ram_we), 32'(!kind[c]));
        if (!kind[c]) chk(ram_wdata == dbuf[c], "R5 ram_wdata", 32'(ram_wdata), 32'(dbuf[c]));
        served[c] = 1; dn = 1; dn_ch = c; dn_rd = kind[c]; dn_val = mem[ram_addr];
        if (lg && lch == c) relog[c] = 1;
      end
      if (lg) begin
        pend[lch] = 1; kind[lch] = f_rd; abuf[lch] = f_addr;
        if (!f_rd) dbuf[lch] = f_data;
      end
      if (svc_win) begin served[0] = 0; served[1] = 0; end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    cycles++;
    chk(in_ready == !txv, "R3 in_ready", 32'(in_ready), 32'(!txv));
    chk(tx_valid == txv, "R2 tx_valid", 32'(tx_valid), 32'(txv));
    if (txv) chk(tx_data == txd, "R2 tx_data", 32'(tx_data), 32'(txd));
    chk(busy == {pend[1], pend[0]}, "R4 busy", 32'(busy), 32'({pend[1], pend[0]}));
    chk(irq == ({irqf[1], irqf[0]} & irq_en), "R6 irq", 32'(irq), 32'({irqf[1], irqf[0]} & irq_en));
    if (tx_valid && tx_ready) begin last_tx = tx_data; tx_cnt++; end
  end

  task automatic send_byte(input bit f, input logic [7:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_first = f; in_data = d;
    @(negedge clk);
    in_valid = 0; in_first = 0;
  endtask

  task automatic wr(input int ch, input logic [7:0] a, input logic [15:0] d);
    send_byte(1, 8'(ch)); send_byte(0, a); send_byte(0, d[15:8]); send_byte(0, d[7:0]);
    @(negedge clk);
  endtask

  task automatic rd(input int ch, input logic [7:0] a);
    send_byte(1, 8'h80 | 8'(ch)); send_byte(0, a); send_byte(0, 8'h00); send_byte(0, 8'h00);
    @(negedge clk);
  endtask

  task automatic window();
    svc_win = 1; @(negedge clk); svc_win = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = memval(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 2'b00 && irq == 2'b00, "R10 busy/irq after reset", 32'({busy, irq}), 0);
    chk(!tx_valid && in_ready, "R10 tx_valid/in_ready after reset", 32'({tx_valid, in_ready}), 32'h1);

    // R1 stray byte and malformed control byte start nothing
    send_byte(0, 8'h33); send_byte(0, 8'h00); send_byte(0, 8'h00); send_byte(0, 8'h00);
    send_byte(1, 8'h42); send_byte(0, 8'h10); send_byte(0, 8'h00); send_byte(0, 8'h00);
    @(negedge clk);
    chk(busy == 2'b00 && !tx_valid, "R1 ignored bytes", 32'(busy), 0);

    // R4 write logs request, R5 no RAM traffic without a window
    irq_en = 2'b01;
    wr(0, 8'd10, 16'hBEEF);
    chk(busy == 2'b01, "R4 busy after write", 32'(busy), 32'h1);
    repeat (10) @(negedge clk);
    chk(ram_cnt == 0, "R5 no access without window", ram_cnt, 0);

    // R6 service clears busy, raises irq, clear works
    window();
    chk(busy == 2'b00 && irq == 2'b01, "R6 busy/irq after service", 32'({busy, irq}), 32'h1);
    chk(mem[10] == 16'hBEEF, "R5 write reached RAM", 32'(mem[10]), 32'hBEEF);
    irq_clr = 2'b01; @(negedge clk); irq_clr = 2'b00;
    chk(irq == 2'b00, "R6 irq cleared", 32'(irq), 0);

    // R2/R7 read pipeline on channel 1
    rd(1, 8'd5);
    chk(last_tx == 16'h0000, "R2 first read returns reset buffer", 32'(last_tx), 0);
    window();
    rd(1, 8'd6);
    chk(last_tx == memval(5), "R7 read returns previous address", 32'(last_tx), 32'(memval(5)));
    window();
    rd(1, 8'd6);
    chk(last_tx == memval(6), "R7 pipeline second step", 32'(last_tx), 32'(memval(6)));
    window();

    // R8 overwrite of a pending request
    ram_cnt = 0;
    wr(1, 8'd30, 16'h1111);
    wr(1, 8'd30, 16'h2222);
    chk(busy[1] == 1'b1, "R8 busy stays set", 32'(busy), 32'h2);
    window();
    chk(ram_cnt == 1, "R8 one access for replaced request", ram_cnt, 1);
    chk(mem[30] == 16'h2222, "R8 newest data written", 32'(mem[30]), 32'h2222);

    // R9 both channels in one window, channel 0 first (model)
    irq_en = 2'b11;
    irq_clr = 2'b11; @(negedge clk); irq_clr = 2'b00;
    ram_cnt = 0;
    wr(0, 8'd40, 16'hAAAA);
    wr(1, 8'd41, 16'hBBBB);
    chk(busy == 2'b11, "R9 both pending", 32'(busy), 32'h3);
    window();
    chk(ram_cnt == 2 && busy == 2'b00 && irq == 2'b11, "R9 both served", ram_cnt, 2);
    chk(mem[40] == 16'hAAAA && mem[41] == 16'hBBBB, "R9 both written", 32'({mem[40], mem[41]}), 32'hAAAABBBB);

    // R3 back-pressure on the outgoing word
    tx_ready = 0;
    send_byte(1, 8'h80); send_byte(0, 8'd40);
    repeat (5) @(negedge clk);
    chk(tx_valid && !in_ready, "R3 word held, input stalled", 32'({tx_valid, in_ready}), 32'h2);
    chk(tx_data == 16'hAAAA, "R3 held word value", 32'(tx_data), 32'hAAAA);
    tx_ready = 1;
    send_byte(0, 8'h00); send_byte(0, 8'h00);
    @(negedge clk);
    chk(last_tx == 16'hAAAA && !tx_valid, "R3 word released", 32'(last_tx), 32'hAAAA);
    window();
    report();
  end

  initial begin
    wait (cycles > 100000);
    chk(0, "watchdog expired", cycles, 100000);
    report();
  end
endmodule